// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block holds the instruction address register of a small controller core, together with an eight-entry hardware stack for return addresses. Each cycle the instruction decoder raises at most one intent: step, jump, call, return, return from interrupt, or interrupt entry. The block then updates the counter and the stack. Reset and interrupt entry force fixed vector addresses. Call and interrupt entry push onto the stack, and the two return flavours pop from it.

The counter spans a 13-bit logical space of 8K words. Only 1K words of program storage exist, so the address sent to program memory keeps just the low ten bits. Any logical address above 03FFh therefore aliases into the implemented region, while the full 13-bit value is still kept and stacked. The stack is a circular buffer that cannot be seen by software. It silently wraps on overflow and underflow.

Top module: `pc_stack_top`

## Requirements
- R1: While rst_ni is low the counter is 0000h, the stack pointer is cleared and every stack slot holds 0000h.
- R2: With only step_i asserted, the counter advances by one at the clock edge, wrapping from 1FFFh to 0000h.
- R3: fetch_addr_o always equals bits 9:0 of pc_o. For example, 0400h fetches 000h and 0ABCh fetches 2BCh.
- R4: With jump_i as the highest-priority request, the counter loads target_i.
- R5: A call loads target_i into the counter and pushes the counter value plus one. The next return reloads that pushed value.
- R6: Nested calls and interrupts unwind in last-in, first-out order, up to eight deep.
- R7: A ninth outstanding push overwrites the oldest slot. After nine pushes, nine pops return the 9th, 8th, … 2nd pushed values and then the 9th value again. No flag is raised.
- R8: Interrupt entry pushes the current counter value, not that value plus one, and loads 0004h.
- R9: Priority, from highest: interrupt entry, then return (either flavour), then call, then jump, then step. When an interrupt and a return arrive together, the counter loads 0004h and the stack ends unchanged, so a later return yields the address that the simultaneous return would have popped.
- R10: ret_i and reti_i have identical effect on the counter and the stack.
- R11: With no request asserted, the counter holds its value.
- R12: A return issued on an empty stack directly after reset loads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance counter by one |
| jump_i | input | 1 | Load target_i |
| call_i | input | 1 | Push counter+1 and load target_i |
| ret_i | input | 1 | Pop return address into counter |
| reti_i | input | 1 | Return from interrupt (pop into counter) |
| irq_i | input | 1 | Interrupt entry: push counter, load 0004h |
| target_i | input | 13 | Jump or call destination |
| pc_o | output | 13 | Full logical counter value |
| fetch_addr_o | output | 10 | Folded program memory address |

## Verification
The bench drives the counter past 03FFh and through 1FFFh. A design that forwarded too many bits, or wrapped at the wrong width, would then show a wrong fetch or a wrong counter after the carry. Nine nested calls followed by nine returns expose a stack that saturates, refuses the ninth push, or mis-steps its pointer. Such a stack would return the wrong address sequence instead of repeating the newest one. A simultaneous interrupt and return checks both that the vector wins and that the stack stays balanced; an off-by-one pop would show up on the following return. An interrupt that pushed counter+1 would resume one instruction late.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_STEP,
    SEL_JUMP,
    SEL_CALL,
    SEL_RET,
    SEL_IRQ,
    SEL_IRQ_RET
  } pc_sel_e;
endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic    step_i,
  input  logic    jump_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    reti_i,
  input  logic    irq_i,
  output pc_sel_e sel_o,
  output logic    push_o,
  output logic    pop_o
);
  logic any_ret;
  assign any_ret = ret_i | reti_i;

  always_comb begin
    sel_o  = SEL_HOLD;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (irq_i && any_ret) begin
      // pop then push of the same value: stack is left as it was
      sel_o = SEL_IRQ_RET;
    end else if (irq_i) begin
      sel_o  = SEL_IRQ;
      push_o = 1'b1;
    end else if (any_ret) begin
      sel_o = SEL_RET;
      pop_o = 1'b1;
    end else if (call_i) begin
      sel_o  = SEL_CALL;
      push_o = 1'b1;
    end else if (jump_i) begin
      sel_o = SEL_JUMP;
    end else if (step_i) begin
      sel_o = SEL_STEP;
    end
  end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] rd_ptr;
  logic [W-1:0]     slot_q [DEPTH];

  assign rd_ptr = sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_q + 1'b1;
    else if (pop_i)  sp_q <= sp_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q[g] <= '0;
      else if (push_i && sp_q == PTR_W'(g)) slot_q[g] <= wdata_i;
    end
  end

  assign top_o = slot_q[rd_ptr];
endmodule

// File: rtl/pcs_fold.sv
module pcs_fold #(
  parameter int PC_W    = 13,
  parameter int FETCH_W = 10
) (
  input  logic [PC_W-1:0]    pc_i,
  output logic [FETCH_W-1:0] addr_o
);
  if (FETCH_W < PC_W) begin : g_trunc
    assign addr_o = pc_i[FETCH_W-1:0];
  end else begin : g_pad
    assign addr_o = FETCH_W'(pc_i);
  end
endmodule

// File: rtl/pc_stack_top.sv
module pc_stack_top
  import pcs_pkg::*;
#(
  parameter int          PC_W    = 13,
  parameter int          FETCH_W = 10,
  parameter int          DEPTH   = 8,
  parameter logic [12:0] RST_VEC = 13'h0000,
  parameter logic [12:0] IRQ_VEC = 13'h0004
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               jump_i,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic               reti_i,
  input  logic               irq_i,
  input  logic [PC_W-1:0]    target_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [FETCH_W-1:0] fetch_addr_o
);
  pc_sel_e         sel;
  logic            push, pop;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, stk_top, stk_wdata;

  pcs_ctrl u_ctrl (
    .step_i (step_i),
    .jump_i (jump_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .reti_i (reti_i),
    .irq_i  (irq_i),
    .sel_o  (sel),
    .push_o (push),
    .pop_o  (pop)
  );

  assign pc_inc    = pc_q + 1'b1;
  assign stk_wdata = (sel == SEL_IRQ) ? pc_q : pc_inc;

  pcs_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (stk_wdata),
    .top_o   (stk_top)
  );

  always_comb begin
    unique case (sel)
      SEL_STEP:              pc_d = pc_inc;
      SEL_JUMP, SEL_CALL:    pc_d = target_i;
      SEL_RET:               pc_d = stk_top;
      SEL_IRQ, SEL_IRQ_RET:  pc_d = PC_W'(IRQ_VEC);
      default:               pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= PC_W'(RST_VEC);
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  pcs_fold #(.PC_W(PC_W), .FETCH_W(FETCH_W)) u_fold (
    .pc_i   (pc_q),
    .addr_o (fetch_addr_o)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int          PC_W    = 13,
  parameter int          FETCH_W = 10,
  parameter logic [12:0] IRQ_VEC = 13'h0004
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               step_i,
  input logic               jump_i,
  input logic               call_i,
  input logic               ret_i,
  input logic               reti_i,
  input logic               irq_i,
  input logic [PC_W-1:0]    target_i,
  input logic [PC_W-1:0]    pc_o,
  input logic [FETCH_W-1:0] fetch_addr_o
);
  logic only_step, only_jump, only_call, only_ret;
  assign only_step = step_i && !jump_i && !call_i && !ret_i && !reti_i && !irq_i;
  assign only_jump = jump_i && !call_i && !ret_i && !reti_i && !irq_i;
  assign only_call = call_i && !ret_i && !reti_i && !irq_i;
  assign only_ret  = (ret_i || reti_i) && !irq_i;

  AST_RESET_PC: assert property (@(posedge clk_i) !rst_ni |-> pc_o == '0); // R1

  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_step |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R2

  AST_FETCH_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o == pc_o[FETCH_W-1:0]); // R3

  AST_JUMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_jump |=> pc_o == $past(target_i)); // R4

  AST_CALL_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_call ##1 only_ret |=> pc_o == PC_W'($past(pc_o, 2) + 1'b1)); // R5

  AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> pc_o == PC_W'(IRQ_VEC)); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i || jump_i || call_i || ret_i || reti_i || irq_i) |=> $stable(pc_o)); // R11
endmodule

bind pc_stack_top pcs_checker #(
  .PC_W(PC_W), .FETCH_W(FETCH_W), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .step_i       (step_i),
  .jump_i       (jump_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .reti_i       (reti_i),
  .irq_i        (irq_i),
  .target_i     (target_i),
  .pc_o         (pc_o),
  .fetch_addr_o (fetch_addr_o)
);

// File: tb/sim_pc_stack_top.sv
module sim_pc_stack_top;
  localparam int OP_HOLD = 0, OP_STEP = 1, OP_JUMP = 2, OP_CALL = 3,
                 OP_RET = 4, OP_RETI = 5, OP_IRQ = 6, OP_IRQ_RET = 7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 0, jump_i = 0, call_i = 0, ret_i = 0, reti_i = 0, irq_i = 0;
  logic [12:0] target_i = '0;
  logic [12:0] pc_o;
  logic [9:0]  fetch_addr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pc_stack_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .jump_i(jump_i),
    .call_i(call_i), .ret_i(ret_i), .reti_i(reti_i), .irq_i(irq_i),
    .target_i(target_i), .pc_o(pc_o), .fetch_addr_o(fetch_addr_o)
  );

  // {req[3:0], op[2:0], target[12:0], expected pc[12:0]}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {4'd2,  3'(OP_STEP),    13'h0000, 13'h0001},  // R2
    {4'd3,  3'(OP_JUMP),    13'h0400, 13'h0400},  // R3 R4 fetch 000h
    {4'd2,  3'(OP_STEP),    13'h0000, 13'h0401},
    {4'd5,  3'(OP_CALL),    13'h1FFF, 13'h1FFF},  // R5 push 0402h
    {4'd2,  3'(OP_STEP),    13'h0000, 13'h0000},  // R2 wrap
    {4'd5,  3'(OP_CALL),    13'h0100, 13'h0100},  // push 0001h
    {4'd8,  3'(OP_IRQ),     13'h0000, 13'h0004},  // R8 push 0100h
    {4'd2,  3'(OP_STEP),    13'h0000, 13'h0005},
    {4'd10, 3'(OP_RETI),    13'h0000, 13'h0100},  // R10
    {4'd11, 3'(OP_HOLD),    13'h0000, 13'h0100},  // R11
    {4'd6,  3'(OP_RET),     13'h0000, 13'h0001},  // R6
    {4'd5,  3'(OP_CALL),    13'h0200, 13'h0200},  // push 0002h
    {4'd9,  3'(OP_IRQ_RET), 13'h0000, 13'h0004},  // R9
    {4'd9,  3'(OP_RET),     13'h0000, 13'h0002},  // R9 balanced stack
    {4'd6,  3'(OP_RET),     13'h0000, 13'h0402},
    {4'd3,  3'(OP_JUMP),    13'h0ABC, 13'h0ABC}   // fetch 2BCh
  };

  task automatic check(input string req, input logic [12:0] exp);
    checks++;
    if (pc_o !== exp) begin
      errors++;
      $display("FAIL %s pc_o actual %h expected %h", req, pc_o, exp);
    end
    checks++;
    if (fetch_addr_o !== exp[9:0]) begin
      errors++;
      $display("FAIL %s fetch_addr_o actual %h expected %h", req, fetch_addr_o, exp[9:0]);
    end
  endtask

  task automatic do_op(input int op, input logic [12:0] tgt);
    @(negedge clk);
    target_i = tgt;
    step_i = (op == OP_STEP);
    jump_i = (op == OP_JUMP);
    call_i = (op == OP_CALL);
    ret_i  = (op == OP_RET) || (op == OP_IRQ_RET);
    reti_i = (op == OP_RETI);
    irq_i  = (op == OP_IRQ) || (op == OP_IRQ_RET);
    @(posedge clk);
    #1;
    {step_i, jump_i, call_i, ret_i, reti_i, irq_i} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [12:0] pushed [9];
    repeat (2) @(negedge clk);
    check("R1", 13'h0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(int'(VEC[i][28:26]), VEC[i][25:13]);
      check($sformatf("R%0d", VEC[i][32:29]), VEC[i][12:0]);
    end

    // R1: reset in the middle of activity
    do_op(OP_JUMP, 13'h0321);
    @(negedge clk);
    rst_ni = 1'b0;
    #1 check("R1", 13'h0000);
    @(negedge clk);
    rst_ni = 1'b1;

    // R12: pop on empty stack straight after reset
    do_op(OP_RET, 13'h0000);
    check("R12", 13'h0000);

    // R4 over R2: jump wins against step when both are raised
    @(negedge clk);
    target_i = 13'h0155; jump_i = 1'b1; step_i = 1'b1;
    @(posedge clk); #1;
    {step_i, jump_i} = '0;
    check("R9", 13'h0155);

    // R7: nine pushes wrap over the oldest slot
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      pushed[k-1] = 13'((k - 1) * 16 + 1);
      do_op(OP_CALL, 13'(k * 16));
      check("R6", 13'(k * 16));
    end
    for (int k = 9; k >= 2; k--) begin
      do_op(OP_RET, 13'h0000);
      check("R7", pushed[k-1]);
    end
    do_op(OP_RET, 13'h0000);
    check("R7", pushed[8]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule